// File: doc/BRIEF.md
# Descriptor-Driven Receive Buffer Manager

This block sits behind a UART bit receiver and moves each received character into memory. The memory is split into buffers. A ring of eight receive descriptors describes them. Each descriptor holds a buffer start address, a received-length field and four control flags. The block writes every stored character out through a single memory write port. It keeps a count of the bytes in the current buffer.

A buffer is closed when it reaches the shared maximum length. It is also closed when a programmable number of idle-character times pass with no new character. On closing, the block writes the byte count into the descriptor and normally marks the descriptor as no longer empty. It may pulse an interrupt, and then moves on to the next descriptor in the ring. A character that arrives while the current descriptor is not empty is dropped and reported. Software fills and re-arms descriptors through a write port and reads them back through a combinational read port.

Top module: `rx_desc_mgr`

## Requirements
- R1: While `rst_n` is low or `en` is low, `hunting` is 1, `cur_idx` is 0 and `mem_we` stays 0. The descriptor contents are kept while `en` is low.
- R2: After enable the block stays in hunt (`hunting`=1) until the first `rx_valid`. Idle ticks during hunt change nothing. The first character clears `hunting` in the following cycle.
- R3: A character that arrives while the current descriptor's empty flag (bit 0) is 1 is written one cycle later. The write appears as `mem_we`=1 with `mem_data` equal to the character and `mem_addr` equal to start (bits [23:12]) plus the number of bytes already in the buffer.
- R4: When the byte count reaches `max_len`, the buffer closes in the same cycle as that write, with length `max_len`.
- R5: Closing a descriptor writes the byte count into bits [11:4]. It clears bit 0 unless bit 3 is set, and leaves start, bits 1 to 3 and all other descriptors unchanged.
- R6: Closing a descriptor whose bit 2 is set gives a one-cycle `irq` pulse in the cycle after the close. A close with bit 2 clear gives no pulse.
- R7: After a close, `cur_idx` moves to 0 if the closed descriptor's wrap flag (bit 1) was set or if it was descriptor 7. Otherwise `cur_idx` moves to the next index. Further characters continue in that descriptor.
- R8: A character that arrives while the current descriptor's bit 0 is 0 is discarded. It causes no memory write and leaves the descriptor unchanged, and `busy_err` pulses for one cycle.
- R9: A descriptor closed with continuous-mode bit 3 set keeps bit 0 at 1, so it accepts data again on its next visit.
- R10: With `max_idle` nonzero, each stored character reloads the idle counter to `max_idle`. Each `idle_tick` in a cycle without `rx_valid` counts it down. The tick that would reach zero closes a buffer holding at least one byte, with length equal to the byte count.
- R11: With `max_idle` equal to 0, idle ticks never close a buffer.
- R12: Idle ticks never close a buffer that holds no bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Receive enable; low forces hunt and descriptor 0 |
| rx_valid | input | 1 | One-cycle strobe for a received character |
| rx_byte | input | 8 | Received character |
| idle_tick | input | 1 | One pulse per idle-character time on the line |
| max_len | input | 8 | Buffer length shared by all descriptors (at least 1) |
| max_idle | input | 16 | Idle-character timeout; 0 disables it |
| desc_we | input | 1 | Descriptor write strobe; applied after any close in the same cycle |
| desc_wr_idx | input | 3 | Descriptor written |
| desc_wdata | input | 24 | Descriptor word: start[23:12], length[11:4], cont[3], irq[2], wrap[1], empty[0] |
| desc_rd_idx | input | 3 | Descriptor read back |
| desc_rdata | output | 24 | Combinational read-back word |
| mem_we | output | 1 | Buffer memory write strobe |
| mem_addr | output | 12 | Buffer memory write address |
| mem_data | output | 8 | Buffer memory write data |
| irq | output | 1 | Completion interrupt pulse |
| busy_err | output | 1 | Pulse for a character dropped on a non-empty descriptor |
| hunting | output | 1 | 1 while waiting for the first character |
| cur_idx | output | 3 | Index of the current descriptor |

## Verification
The hardest situation to reach is an idle-timeout close that races with other events. The timeout can coincide with a descriptor rewrite. It can strike a partly filled buffer just after an overflow into the next descriptor, or come just after a wrap that lands on a descriptor software has not yet re-armed. The directed phase walks this path step by step. It fills a buffer past its length, lets the idle count run out on the spill-over, and then reaches a non-empty descriptor through the wrap flag. A long random phase follows. In it, characters, idle ticks, descriptor re-arms and enable drops mix freely, with a short buffer length and small idle limits, so these collisions happen many times. A behavioural model checks every cycle.

// File: rtl/rx_desc_mgr.sv
module rx_desc_mgr #(
  parameter int NDESC  = 8,
  parameter int LEN_W  = 8,
  parameter int ADDR_W = 12,
  parameter int IDLE_W = 16,
  localparam int IW = $clog2(NDESC),
  localparam int DW = 4 + LEN_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              idle_tick,
  input  logic [LEN_W-1:0]  max_len,
  input  logic [IDLE_W-1:0] max_idle,
  input  logic              desc_we,
  input  logic [IW-1:0]     desc_wr_idx,
  input  logic [DW-1:0]     desc_wdata,
  input  logic [IW-1:0]     desc_rd_idx,
  output logic [DW-1:0]     desc_rdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_data,
  output logic              irq,
  output logic              busy_err,
  output logic              hunting,
  output logic [IW-1:0]     cur_idx
);
  localparam int LEN_LSB   = 4;
  localparam int START_LSB = 4 + LEN_W;

  logic [DW-1:0]     desc [NDESC];
  logic [LEN_W-1:0]  cnt;
  logic [IDLE_W-1:0] idle_cnt;

  logic [DW-1:0] cur;
  assign cur = desc[cur_idx];

  wire              cur_e     = cur[0];
  wire              cur_wrap  = cur[1];
  wire              cur_irq   = cur[2];
  wire              cur_cont  = cur[3];
  wire [ADDR_W-1:0] cur_start = cur[START_LSB +: ADDR_W];

  wire [LEN_W-1:0] cnt_nxt  = cnt + 1'b1;
  wire             store    = en && rx_valid && cur_e;
  wire             drop     = en && rx_valid && !cur_e;
  wire             idle_on  = en && !rx_valid && idle_tick && !hunting
                              && (cnt != '0) && (max_idle != '0);
  wire             idle_hit = idle_on && (idle_cnt <= 1);
  wire             close    = (store && cnt_nxt == max_len) || idle_hit;
  wire [LEN_W-1:0] close_len = store ? cnt_nxt : cnt;
  wire [IW-1:0]    next_idx  = (cur_wrap || cur_idx == IW'(NDESC - 1)) ? '0 : cur_idx + 1'b1;

  assign desc_rdata = desc[desc_rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NDESC; i++) desc[i] <= '0;
      cnt      <= '0;
      idle_cnt <= '0;
      cur_idx  <= '0;
      hunting  <= 1'b1;
      mem_we   <= 1'b0;
      mem_addr <= '0;
      mem_data <= '0;
      irq      <= 1'b0;
      busy_err <= 1'b0;
    end else begin
      mem_we   <= store;
      irq      <= close && cur_irq;
      busy_err <= drop;
      if (!en) begin
        hunting  <= 1'b1;
        cur_idx  <= '0;
        cnt      <= '0;
        idle_cnt <= '0;
      end else begin
        if (rx_valid) hunting <= 1'b0;
        if (store) begin
          mem_addr <= cur_start + ADDR_W'(cnt);
          mem_data <= rx_byte;
          idle_cnt <= max_idle;
          cnt      <= cnt_nxt;
        end else if (idle_on && !idle_hit) begin
          idle_cnt <= idle_cnt - 1'b1;
        end
        if (close) begin
          desc[cur_idx] <= {cur_start, close_len, cur_cont, cur_irq, cur_wrap, cur_e & cur_cont};
          cur_idx <= next_idx;
          cnt     <= '0;
        end
      end
      if (desc_we) desc[desc_wr_idx] <= desc_wdata;
    end
  end
endmodule

// File: rtl/rx_desc_mgr_chk.sv
module rx_desc_mgr_chk #(
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          rx_valid,
  input logic          idle_tick,
  input logic          mem_we,
  input logic          irq,
  input logic          busy_err,
  input logic          hunting,
  input logic [IW-1:0] cur_idx
);
  AST_WE_FOLLOWS_RX: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> $past(rx_valid && en)); // R3

  AST_OFF_HUNTS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!mem_we && hunting && cur_idx == '0)); // R1

  AST_HUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && hunting && !rx_valid) |=> hunting); // R2

  AST_DROP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && busy_err)); // R8

  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(en && (rx_valid || idle_tick))); // R6

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && cur_idx != $past(cur_idx))
      |-> (cur_idx == '0 || cur_idx == IW'($past(cur_idx) + 1))); // R7
endmodule

bind rx_desc_mgr rx_desc_mgr_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .rx_valid(rx_valid), .idle_tick(idle_tick),
  .mem_we(mem_we), .irq(irq), .busy_err(busy_err), .hunting(hunting), .cur_idx(cur_idx)
);

// File: tb/rx_desc_mgr_test.sv
`timescale 1ns/1ps
module rx_desc_mgr_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        en = 0;
  logic        rx_valid = 0;
  logic [7:0]  rx_byte = 0;
  logic        idle_tick = 0;
  logic [7:0]  max_len = 4;
  logic [15:0] max_idle = 3;
  logic        desc_we = 0;
  logic [2:0]  desc_wr_idx = 0;
  logic [23:0] desc_wdata = 0;
  logic [2:0]  desc_rd_idx = 0;
  logic [23:0] desc_rdata;
  logic        mem_we, irq, busy_err, hunting;
  logic [11:0] mem_addr;
  logic [7:0]  mem_data;
  logic [2:0]  cur_idx;

  rx_desc_mgr uut (.*);

  always #2.5 clk = ~clk;

  int tests = 0, fails = 0, cycles = 0, irqs = 0;

  // behavioural reference
  logic [23:0] m_desc [8];
  int m_idx, m_cnt, m_idle;
  bit m_hunt;
  bit e_we, e_irq, e_busy;
  logic [11:0] e_addr;
  logic [7:0]  e_data;

  always @(posedge clk) begin
    logic [23:0] d;
    bit closing;
    int clen;
    e_we = 0; e_irq = 0; e_busy = 0;
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) m_desc[i] = 0;
      m_idx = 0; m_cnt = 0; m_idle = 0; m_hunt = 1;
    end else begin
      if (!en) begin
        m_hunt = 1; m_idx = 0; m_cnt = 0; m_idle = 0;
      end else begin
        d = m_desc[m_idx]; closing = 0; clen = 0;
        if (rx_valid) begin
          m_hunt = 0;
          if (!d[0]) e_busy = 1;
          else begin
            e_we = 1; e_addr = 12'(d[23:12] + m_cnt); e_data = rx_byte;
            m_idle = max_idle; m_cnt++;
            if (m_cnt == max_len) begin closing = 1; clen = m_cnt; end
          end
        end else if (idle_tick && !m_hunt && m_cnt > 0 && max_idle != 0) begin
          if (m_idle <= 1) begin closing = 1; clen = m_cnt; end
          else m_idle--;
        end
        if (closing) begin
          d[11:4] = 8'(clen);
          if (!d[3]) d[0] = 0;
          m_desc[m_idx] = d;
          e_irq = d[2];
          m_idx = (d[1] || m_idx == 7) ? 0 : m_idx + 1;
          m_cnt = 0;
        end
      end
      if (desc_we) m_desc[desc_wr_idx] = desc_wdata;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (irq) irqs++;
    if (rst_n) begin
      chk(mem_we == e_we, "R3 mem_we", mem_we, e_we);
      if (e_we) begin
        chk(mem_addr == e_addr, "R3 mem_addr", mem_addr, e_addr);
        chk(mem_data == e_data, "R3 mem_data", mem_data, e_data);
      end
      chk(irq == e_irq, "R6 irq", irq, e_irq);
      chk(busy_err == e_busy, "R8 busy_err", busy_err, e_busy);
      chk(hunting == m_hunt, "R2 hunting", hunting, m_hunt);
      chk(cur_idx == 3'(m_idx), "R7 cur_idx", cur_idx, m_idx);
    end
  end

  function automatic logic [23:0] mk(input int start, input bit wrap, input bit ie, input bit cont);
    return {12'(start), 8'h0, cont, ie, wrap, 1'b1};
  endfunction

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin idle_tick = 1; @(negedge clk); end
    idle_tick = 0;
  endtask

  task automatic send(input logic [7:0] b);
    rx_byte = b; rx_valid = 1; @(negedge clk); rx_valid = 0;
  endtask

  task automatic wdesc(input int idx, input logic [23:0] w);
    desc_wr_idx = 3'(idx); desc_wdata = w; desc_we = 1; @(negedge clk); desc_we = 0;
  endtask

  task automatic cdesc(input int idx, input logic [23:0] exp, input string tag);
    desc_rd_idx = 3'(idx); #0.5;
    chk(desc_rdata == exp, tag, desc_rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(hunting == 1 && cur_idx == 0 && mem_we == 0 && irq == 0, "R1 reset", {hunting, cur_idx}, 4'b1000);
    rst_n = 1;
    wdesc(0, mk('h100, 0, 1, 0));
    wdesc(1, mk('h200, 0, 1, 0));
    wdesc(2, mk('h300, 0, 1, 1));
    wdesc(3, mk('h400, 1, 0, 0));
    en = 1;
    tick(5);
    chk(hunting == 1, "R2 idle in hunt", hunting, 1);
    for (int k = 0; k < 6; k++) send(8'(8'h10 + k));
    cdesc(0, {12'h100, 8'd4, 4'b0100}, "R4 full close length");
    chk(cur_idx == 1, "R7 overflow moves on", cur_idx, 1);
    tick(3);
    cdesc(1, {12'h200, 8'd2, 4'b0100}, "R10 idle close");
    tick(5);
    chk(cur_idx == 2, "R12 empty buffer kept", cur_idx, 2);
    for (int k = 0; k < 4; k++) send(8'(8'h30 + k));
    cdesc(2, {12'h300, 8'd4, 4'b1101}, "R9 continuous stays empty");
    for (int k = 0; k < 4; k++) send(8'(8'h40 + k));
    chk(cur_idx == 0, "R7 wrap flag", cur_idx, 0);
    cdesc(3, {12'h400, 8'd4, 4'b0010}, "R5 close fields");
    send(8'hEE);
    cdesc(0, {12'h100, 8'd4, 4'b0100}, "R8 dropped char leaves desc");
    chk(irqs == 3, "R6 irq count", irqs, 3);
    max_idle = 0;
    wdesc(0, mk('h500, 0, 1, 0));
    send(8'h01); send(8'h02);
    tick(20);
    cdesc(0, mk('h500, 0, 1, 0), "R11 timeout disabled");
    en = 0; @(negedge clk);
    chk(hunting == 1 && cur_idx == 0, "R1 disable", {hunting, cur_idx}, 4'b1000);
    en = 1; max_len = 3;
    for (int c = 0; c < 6000; c++) begin
      rx_byte = 8'($urandom);
      rx_valid = ($urandom % 4) == 0;
      idle_tick = ($urandom % 3) == 0;
      desc_we = ($urandom % 12) == 0;
      desc_wr_idx = 3'($urandom);
      desc_wdata = {12'($urandom), 8'h0, ($urandom % 6) == 0, 1'($urandom),
                    ($urandom % 8) == 0, ($urandom % 5) != 0};
      if ($urandom % 500 == 0) en = 0; else en = 1;
      if ($urandom % 300 == 0) max_idle = 16'($urandom % 6);
      @(negedge clk);
    end
    rx_valid = 0; idle_tick = 0; desc_we = 0;
    @(negedge clk);
    for (int i = 0; i < 8; i++) cdesc(i, m_desc[i], "R5 table after random run");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule